// File: doc/BRIEF.md
# Programmable single-line interrupt trigger controller

This block conditions one asynchronous external interrupt pin and turns it into a single registered interrupt request for an upstream interrupt controller. The pin is brought into the clock domain through a flop chain. The block then qualifies it by one of four trigger modes: active-low level, falling edge, active-high level or rising edge. A qualified event is held in a pending bit until software acknowledges it.

Software sees three 32-bit registers on a simple write-enable/address/data port. Reads are combinational.

- **Control** sits at offset 0x00. Bits [1:0] hold the trigger mode. The remaining bits are plain storage.
- **Pending** sits at offset 0x04. Bit 0 reads the latched event. Writing 1 to bit 0 clears it.
- **Enable** is at 0x08 or 0x34, chosen by the `MAP_ALT` parameter. Bit 0 gates the request.

The request is the registered AND of pending and enable. Pending keeps collecting events while the request is masked.

Top module: `nmi_trig_ctrl`

## Requirements
- R1: After reset the control register reads 0, the enable register reads 0 and `irq_o` is 0.
- R2: Control bits [1:0] choose the trigger: 0 means pin low, 1 means a falling edge, 2 means pin high and 3 means a rising edge.
- R3: A write to control stores all 32 bits. A later read-modify-write of only bits [1:0] returns bits [31:2] unchanged.
- R4: A pin change reaches the pending bit on the third rising clock edge after it is applied, and reaches `irq_o` on the fourth.
- R5: In edge modes, pending sets on the selected edge and holds. Writing 1 to bit 0 of offset 0x04 clears it. If an edge event and a clear arrive in the same cycle, pending stays set.
- R6: In level modes, pending sets while the level is asserted. A clear has no effect while the level is still asserted. A clear succeeds once the level is gone.
- R7: `irq_o` is the value of pending AND enable (bit 0 of the enable register) one cycle earlier. Pending still latches events while enable is 0.
- R8: The enable register is at offset 0x08 when `MAP_ALT`=0 and at 0x34 when `MAP_ALT`=1. The offset not selected is unmapped.
- R9: A write that changes the trigger field disables edge detection for the following cycle, so an edge that coincides with a mode switch is not latched.
- R10: Reads from any offset other than control, pending and the selected enable offset return 0. Writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register byte offset |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Registered interrupt request to the upstream controller |

## Verification
The pin is driven through each of the four trigger modes:
- Steady high and low levels separate the two level polarities.
- Single rising and falling transitions show that each edge mode reacts only to its own direction.

Clears are placed to tell the edge and level modes apart:
- A clear placed on the exact cycle an edge is detected shows that set takes priority.
- A clear issued while a level is still active shows the level-mode hold.

Other patterns check the remaining behaviour:
- A mode switch issued on the cycle the synchronised pin rises separates suppressed history from a real edge.
- Toggling enable while pending is set shows that the mask acts only on the output.
- Accesses to the unselected enable offset and other holes confirm that the map decode is complete.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO  = 2'd0,
    TRIG_FALL    = 2'd1,
    TRIG_LVL_HI  = 2'd2,
    TRIG_RISE    = 2'd3
  } trig_mode_e;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_PEND   = 8'h04;
  localparam logic [7:0] OFF_EN_STD = 8'h08;
  localparam logic [7:0] OFF_EN_ALT = 8'h34;

  function automatic logic is_edge_mode(trig_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_trig_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  trig_mode_e mode_i,
  input  logic       mode_chg_i,
  output logic       edge_o,
  output logic       evt_o
);
  logic prev_q;
  logic hist_vld_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b0;
      hist_vld_q <= 1'b0;
    end else begin
      prev_q     <= sync_i;
      hist_vld_q <= ~mode_chg_i;  // drop history across a trigger switch
    end
  end

  assign rise = hist_vld_q &  sync_i & ~prev_q;
  assign fall = hist_vld_q & ~sync_i &  prev_q;

  always_comb begin
    edge_o = 1'b0;
    unique case (mode_i)
      TRIG_LVL_LO: evt_o = ~sync_i;
      TRIG_FALL:   begin evt_o = fall; edge_o = fall; end
      TRIG_LVL_HI: evt_o = sync_i;
      TRIG_RISE:   begin evt_o = rise; edge_o = rise; end
      default:     evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_trig_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter bit MAP_ALT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          evt_i,
  output logic [DW-1:0] rdata_o,
  output trig_mode_e    mode_o,
  output logic          mode_chg_o,
  output logic          clr_o,
  output logic          pend_o,
  output logic          en_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_PEND = AW'(OFF_PEND);
  localparam logic [AW-1:0] A_EN   = MAP_ALT ? AW'(OFF_EN_ALT) : AW'(OFF_EN_STD);

  logic [DW-1:0] ctrl_q;
  logic          pend_q, en_q;
  logic          wr_ctrl, wr_pend, wr_en;

  assign wr_ctrl    = we_i && (addr_i == A_CTRL);
  assign wr_pend    = we_i && (addr_i == A_PEND);
  assign wr_en      = we_i && (addr_i == A_EN);
  assign clr_o      = wr_pend && wdata_i[0];
  assign mode_o     = trig_mode_e'(ctrl_q[1:0]);
  assign mode_chg_o = wr_ctrl && (wdata_i[1:0] != ctrl_q[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_en)   en_q   <= wdata_i[0];
      if (evt_i)      pend_q <= 1'b1;   // set beats clear
      else if (clr_o) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)      rdata_o = ctrl_q;
    else if (addr_i == A_PEND) rdata_o[0] = pend_q;
    else if (addr_i == A_EN)   rdata_o[0] = en_q;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/nmi_trig_ctrl.sv
module nmi_trig_ctrl
  import nmi_trig_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit MAP_ALT     = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic       sync_pin;
  trig_mode_e mode;
  logic       mode_chg, clr_wr, evt, edge_evt, pend_q, en_q;
  logic       irq_q;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_pin)
  );

  nmi_detect u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_pin),
    .mode_i    (mode),
    .mode_chg_i(mode_chg),
    .edge_o    (edge_evt),
    .evt_o     (evt)
  );

  nmi_regs #(.AW(AW), .DW(DW), .MAP_ALT(MAP_ALT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .evt_i     (evt),
    .rdata_o   (rdata_o),
    .mode_o    (mode),
    .mode_chg_o(mode_chg),
    .clr_o     (clr_wr),
    .pend_o    (pend_q),
    .en_o      (en_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend_q & en_q;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/nmi_trig_ctrl_chk.sv
module nmi_trig_ctrl_chk #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter bit MAP_ALT = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic          evt,
  input logic          edge_evt,
  input logic          clr_wr,
  input logic          mode_chg,
  input logic          pend_q,
  input logic          en_q
);
  localparam logic [AW-1:0] EN_OFF = MAP_ALT ? AW'(8'h34) : AW'(8'h08);

  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !irq_o);

  p_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && pend_q) |=> irq_o);

  p_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> pend_q);

  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !evt) |=> !pend_q);

  p_mode_sw_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !edge_evt);

  p_hole_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != AW'(0) && addr_i != AW'(4) && addr_i != EN_OFF) |-> (rdata_o == '0));
endmodule

bind nmi_trig_ctrl nmi_trig_ctrl_chk #(.AW(AW), .DW(DW), .MAP_ALT(MAP_ALT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .evt     (evt),
  .edge_evt(edge_evt),
  .clr_wr  (clr_wr),
  .mode_chg(mode_chg),
  .pend_q  (pend_q),
  .en_q    (en_q)
);

// File: tb/tb_nmi_trig_ctrl.sv
`timescale 1ns/1ps
module tb_nmi_trig_ctrl;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] EN_A = 8'h08;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  nmi_trig_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit          pin_hist[$];
  bit          m_last, m_hist_ok, m_pend, m_en, m_irq;
  logic [31:0] m_ctrl;

  function automatic bit m_sync();
    return pin_hist.size() >= 2 ? pin_hist[pin_hist.size()-2] : 1'b0;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h04) return {31'd0, m_pend};
    if (a == EN_A)  return {31'd0, m_en};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist.delete();
      m_last = 0; m_hist_ok = 0; m_pend = 0; m_en = 0; m_irq = 0; m_ctrl = 0;
    end else begin
      bit s, ev, clr, chg;
      s   = m_sync();
      case (m_ctrl[1:0])
        2'd0: ev = !s;
        2'd1: ev = m_hist_ok && !s && m_last;
        2'd2: ev = s;
        default: ev = m_hist_ok && s && !m_last;
      endcase
      clr = we && addr == 8'h04 && wdata[0];
      chg = we && addr == 8'h00 && wdata[1:0] != m_ctrl[1:0];
      m_irq = m_pend && m_en;
      if (ev) m_pend = 1; else if (clr) m_pend = 0;
      m_last = s;
      m_hist_ok = !chg;
      if (we && addr == 8'h00) m_ctrl = wdata;
      if (we && addr == EN_A) m_en = wdata[0];
      pin_hist.push_back(pin);
      if (pin_hist.size() > 2) void'(pin_hist.pop_front());
    end
  end

  task automatic check(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  // per-cycle compare
  always @(negedge clk) if (rst_n) begin
    check(irq === m_irq, {tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    check(rdata === m_read(addr), {tag, " rdata"}, rdata, m_read(addr));
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); #1 addr = a; wdata = d; we = 1;
    @(negedge clk); #1 we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string t);
    @(negedge clk); #1 addr = a;
    @(negedge clk);
    check(rdata === exp, t, rdata, exp);
    #1;
  endtask

  task automatic set_pin(bit v);
    @(negedge clk); #1 pin = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    #1 rst_n = 1;
    tag = "R1";
    check(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    rd_chk(8'h00, 32'h0, "R1 ctrl reset");
    rd_chk(EN_A, 32'h0, "R1 enable reset");

    tag = "R3";
    wr(8'h00, 32'hA5A5_C3F3);
    rd_chk(8'h00, 32'hA5A5_C3F3, "R3 ctrl full write");
    wr(8'h00, 32'hA5A5_C3F0 | 32'd3);
    rd_chk(8'h00, 32'hA5A5_C3F3, "R3 rmw keeps upper bits");

    tag = "R4";
    wr(8'h04, 1);
    wr(EN_A, 1);
    rd_chk(8'h04, 0, "R4 pending clear before edge");
    set_pin(1);
    @(negedge clk); check(rdata[0] === 1'b0, "R4 pend after 1 edge", rdata, 0);
    @(negedge clk); check(rdata[0] === 1'b0, "R4 pend after 2 edges", rdata, 0);
    @(negedge clk); check(rdata[0] === 1'b1, "R4 pend after 3 edges", rdata, 1);
    check(irq === 1'b0, "R4 irq after 3 edges", {31'd0, irq}, 0);
    @(negedge clk); check(irq === 1'b1, "R4 irq after 4 edges", {31'd0, irq}, 1);
    #1;

    tag = "R2";
    wr(8'h04, 1);
    set_pin(0); idle(5);
    rd_chk(8'h04, 0, "R2 rising mode ignores fall");

    tag = "R5";
    wr(8'h00, 32'h1);
    wr(8'h04, 1);
    set_pin(1); idle(5);
    rd_chk(8'h04, 0, "R2 falling mode ignores rise");
    addr = 8'h04;
    set_pin(0);
    @(negedge clk); @(negedge clk); #1 we = 1; wdata = 1;
    @(negedge clk); #1 we = 0;
    rd_chk(8'h04, 1, "R5 set wins over clear");
    idle(4);
    rd_chk(8'h04, 1, "R5 pending sticky");
    wr(8'h04, 1);
    rd_chk(8'h04, 0, "R5 w1c clears");

    tag = "R6";
    wr(8'h00, 32'h2);
    set_pin(1); idle(4);
    wr(8'h04, 1);
    rd_chk(8'h04, 1, "R6 clear ignored while high");
    set_pin(0); idle(4);
    rd_chk(8'h04, 1, "R6 pending holds after level ends");
    wr(8'h04, 1);
    rd_chk(8'h04, 0, "R6 clear after level gone");
    wr(8'h00, 32'h0); idle(4);
    rd_chk(8'h04, 1, "R2 level-low sets pending");
    set_pin(1); idle(4);
    wr(8'h04, 1);
    rd_chk(8'h04, 0, "R6 level-low cleared when pin high");

    tag = "R7";
    wr(8'h00, 32'h1);
    wr(8'h04, 1);
    wr(EN_A, 0);
    set_pin(0); idle(5);
    rd_chk(8'h04, 1, "R7 pending latches while masked");
    check(irq === 1'b0, "R7 irq masked", {31'd0, irq}, 0);
    wr(EN_A, 1); idle(1);
    check(irq === 1'b1, "R7 irq after enable", {31'd0, irq}, 1);
    wr(8'h04, 1); idle(1);
    check(irq === 1'b0, "R7 irq drops after clear", {31'd0, irq}, 0);

    tag = "R9";
    addr = 8'h00;
    set_pin(1);
    #0; @(negedge clk); #1 we = 1; wdata = 32'h3;
    @(negedge clk); #1 we = 0;
    idle(4);
    rd_chk(8'h04, 0, "R9 edge at mode switch not latched");
    set_pin(0); idle(4); set_pin(1); idle(4);
    rd_chk(8'h04, 1, "R9 later rise still detected");
    wr(8'h04, 1);

    tag = "R10";
    rd_chk(8'h34, 0, "R8 alt enable offset unmapped");
    wr(8'h34, 0);
    rd_chk(EN_A, 1, "R8 enable at 0x08 untouched");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h0C, 0, "R10 hole reads zero");
    rd_chk(8'h00, 32'h3, "R10 hole write ignored");
    wr(8'h10, 32'h1);
    rd_chk(8'h04, 0, "R10 pending unaffected by hole write");

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule